// File: doc/BRIEF.md
# Speculative Reorder Buffer

This block tracks in-flight instructions for a core that executes out of order and speculates past branches. Each instruction takes a slot at issue, in program order, and gets the slot number back as its result tag. Functional units later return results on a result bus tagged with that slot number. Dependent instructions can read completed values through a lookup port before those values are committed. Only the oldest slot can leave the buffer, and it does so only once its result is present. At that point it writes the register file or, for a store, memory.

A branch that resolved as mispredicted, or an instruction that recorded a fault, empties the whole buffer when it reaches the oldest position. This keeps architectural state exact at the faulting or redirecting instruction. A separate address check tells the load pipeline whether any store still held in the buffer targets the address a load is about to read.

Top module: `spec_rob`

## Requirements
- R1: An issue request is granted in the same cycle when `issueValid` and `rsFree` are both high, the buffer holds fewer than 8 entries and no flush happens that cycle. `issueTag` gives the slot taken. Slots are handed out in increasing order modulo 8, starting at 0 after reset.
- R2: Kind codes are 2'b00 for a register operation, 2'b01 for a store and 2'b10 for a branch. A retiring register operation raises `regWe` with `regIdx` set to the low 5 bits of its destination and `regData` set to its result. A retiring store raises `memWe` with `memAddr` set to its 16-bit destination and `memData` set to its result. A retiring branch raises neither.
- R3: The buffer holds at most 8 entries. While it holds 8, no issue is granted.
- R4: A result-bus write stores the value, the fault flag and the mispredict flag into the slot named by `resTag` and marks that slot ready. The lookup port reports `lookupValid` high with the stored value only while the named slot is occupied and ready.
- R5: Exactly the oldest entry retires, only when it is ready, at most one per cycle, and in issue order. `retireValid` and `retireTag` identify it, and all write strobes stay low in cycles without a retirement.
- R6: A branch retiring with its mispredict flag set raises `flushOut` and discards every entry. The next slot granted is the one after the branch.
- R7: A fault recorded by an entry has no effect until that entry retires. It then raises `excTaken` and `flushOut`, suppresses the entry's register or memory write, and discards all entries.
- R8: `loadBlock` is high exactly when some occupied entry of kind store has a destination equal to `loadAddr`.
- R9: A result-bus write to a slot that is unoccupied, or that is flushed in the same cycle, changes nothing. A slot reissued later reads as not ready.
- R10: No issue is granted in a cycle that flushes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| issueValid | input | 1 | An instruction asks for a slot |
| issueKind | input | 2 | Kind code of the issuing instruction |
| issueDest | input | 16 | Register number or store address |
| rsFree | input | 1 | A reservation station is available |
| issueGrant | output | 1 | Slot allocated this cycle |
| issueTag | output | 3 | Slot number allocated |
| resValid | input | 1 | Result bus carries a result |
| resTag | input | 3 | Slot the result belongs to |
| resValue | input | 32 | Result value (store data for stores) |
| resExcept | input | 1 | The instruction faulted |
| resMispredict | input | 1 | The branch was mispredicted |
| lookupTag | input | 3 | Slot whose value is requested |
| lookupValid | output | 1 | Requested slot holds a finished result |
| lookupValue | output | 32 | Value of the requested slot |
| loadAddr | input | 16 | Address of a load about to access memory |
| loadBlock | output | 1 | A buffered store matches the load address |
| retireValid | output | 1 | The oldest entry leaves this cycle |
| retireTag | output | 3 | Slot of the retiring entry |
| regWe | output | 1 | Register file write strobe |
| regIdx | output | 5 | Register written |
| regData | output | 32 | Register write data |
| memWe | output | 1 | Memory write strobe |
| memAddr | output | 16 | Memory write address |
| memData | output | 32 | Memory write data |
| flushOut | output | 1 | All entries discarded this cycle |
| excTaken | output | 1 | A fault is taken at the retiring entry |

## Verification
The bench first fills the buffer with a mix of register operations, stores and branches. It then completes them in reverse order, which separates in-order retirement from completion order and exposes the full condition. Directed sequences follow: a mispredicted branch with younger finished work behind it, a fault deferred behind an older entry, and a stale result sent to a flushed slot that is then reissued. These separate flush from retire and show that ignored writes stay ignored. A long pseudo-random sweep then mixes issues, completions to live and dead slots, faults, lookups and small store addresses. A reference model in the bench predicts every output, so pointer wrap and load-conflict matches are covered across many occupancies.

// File: rtl/rob_pkg.sv
package rob_pkg;

  typedef enum logic [1:0] {
    KIND_REG    = 2'b00,
    KIND_STORE  = 2'b01,
    KIND_BRANCH = 2'b10,
    KIND_RSVD   = 2'b11
  } robKind_e;

  // Strobes the control half sends to the entry storage each cycle.
  typedef struct packed {
    logic doIssue;
    logic doRetire;
    logic doFlush;
  } robStrobe_t;

endpackage

// File: rtl/rob_ctrl.sv
module rob_ctrl
  import rob_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int TAG_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             issueValid,
  input  logic             rsFree,
  input  logic             headValid,
  input  logic             headReady,
  input  logic             headExc,
  input  logic             headMisp,
  input  robKind_e         headKind,
  output robStrobe_t       strb,
  output logic [TAG_W-1:0] headIdx,
  output logic [TAG_W-1:0] tailIdx,
  output logic             issueGrant,
  output logic             retireValid,
  output logic             regWe,
  output logic             memWe,
  output logic             flushOut,
  output logic             excTaken
);

  localparam int PTR_W = TAG_W + 1;

  logic [PTR_W-1:0] headPtr;
  logic [PTR_W-1:0] tailPtr;
  logic             isFull;
  logic             retireNow;
  logic             excNow;
  logic             mispNow;
  logic             flushNow;

  // The extra top bit separates a full buffer from an empty one.
  assign isFull  = (tailPtr - headPtr) == PTR_W'(DEPTH);
  assign headIdx = headPtr[TAG_W-1:0];
  assign tailIdx = tailPtr[TAG_W-1:0];

  assign retireNow = headValid && headReady;
  assign excNow    = retireNow && headExc;
  assign mispNow   = retireNow && !headExc && (headKind == KIND_BRANCH) && headMisp;
  assign flushNow  = excNow || mispNow;

  assign issueGrant = issueValid && rsFree && !isFull && !flushNow;

  assign retireValid = retireNow;
  assign regWe       = retireNow && !headExc && (headKind == KIND_REG);
  assign memWe       = retireNow && !headExc && (headKind == KIND_STORE);
  assign flushOut    = flushNow;
  assign excTaken    = excNow;

  assign strb.doIssue  = issueGrant;
  assign strb.doRetire = retireNow;
  assign strb.doFlush  = flushNow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      headPtr <= '0;
      tailPtr <= '0;
    end else begin
      if (retireNow) begin
        headPtr <= headPtr + 1'b1;
      end
      if (flushNow) begin
        tailPtr <= headPtr + 1'b1;
      end else if (issueGrant) begin
        tailPtr <= tailPtr + 1'b1;
      end
    end
  end

  // R6: after a flush the buffer is empty
  assert_flush_empties_R6: assert property (@(posedge clk) disable iff (!rstN)
    flushOut |=> (headPtr == tailPtr));

  // R5: the pointers and the stored occupancy of the oldest slot agree
  assert_head_tracks_R5: assert property (@(posedge clk) disable iff (!rstN)
    (headPtr != tailPtr) == headValid);

  // R1: each grant advances the allocation pointer by one
  assert_tail_moves_R1: assert property (@(posedge clk) disable iff (!rstN)
    issueGrant |=> (tailPtr == PTR_W'($past(tailPtr) + 1'b1)));

  // R7: a taken fault comes from an entry that was ready
  assert_exc_at_ready_head_R7: assert property (@(posedge clk) disable iff (!rstN)
    excTaken |-> (headValid && headReady && headExc));

endmodule

// File: rtl/rob_data.sv
module rob_data
  import rob_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 32,
  parameter int DEST_W = 16,
  parameter int REG_W  = 5,
  localparam int TAG_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  robStrobe_t        strb,
  input  logic [TAG_W-1:0]  headIdx,
  input  logic [TAG_W-1:0]  tailIdx,
  input  robKind_e          issueKind,
  input  logic [DEST_W-1:0] issueDest,
  input  logic              resValid,
  input  logic [TAG_W-1:0]  resTag,
  input  logic [DATA_W-1:0] resValue,
  input  logic              resExcept,
  input  logic              resMispredict,
  input  logic [TAG_W-1:0]  lookupTag,
  output logic              lookupValid,
  output logic [DATA_W-1:0] lookupValue,
  input  logic [DEST_W-1:0] loadAddr,
  output logic              loadBlock,
  output logic              headValid,
  output logic              headReady,
  output logic              headExc,
  output logic              headMisp,
  output robKind_e          headKind,
  output logic [REG_W-1:0]  regIdx,
  output logic [DATA_W-1:0] regData,
  output logic [DEST_W-1:0] memAddr,
  output logic [DATA_W-1:0] memData
);

  logic [DEPTH-1:0]  entValid;
  logic [DEPTH-1:0]  entReady;
  logic [DEPTH-1:0]  entExc;
  logic [DEPTH-1:0]  entMisp;
  robKind_e          entKind  [DEPTH];
  logic [DEST_W-1:0] entDest  [DEPTH];
  logic [DATA_W-1:0] entValue [DEPTH];

  for (genvar e = 0; e < DEPTH; e++) begin : gEntry
    logic              vld;
    logic              rdy;
    logic              exc;
    logic              misp;
    robKind_e          kind;
    logic [DEST_W-1:0] dest;
    logic [DATA_W-1:0] value;
    logic              hitIssue;
    logic              hitRetire;
    logic              hitRes;

    assign hitIssue  = strb.doIssue && (tailIdx == TAG_W'(e));
    assign hitRetire = strb.doRetire && (headIdx == TAG_W'(e));
    // Writes to a slot that is not occupied are dropped.
    assign hitRes    = resValid && (resTag == TAG_W'(e)) && vld;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        vld  <= 1'b0;
        rdy  <= 1'b0;
        exc  <= 1'b0;
        misp <= 1'b0;
      end else if (strb.doFlush) begin
        vld  <= 1'b0;
        rdy  <= 1'b0;
        exc  <= 1'b0;
        misp <= 1'b0;
      end else if (hitIssue) begin
        vld  <= 1'b1;
        rdy  <= 1'b0;
        exc  <= 1'b0;
        misp <= 1'b0;
      end else if (hitRetire) begin
        vld  <= 1'b0;
        rdy  <= 1'b0;
      end else if (hitRes) begin
        rdy  <= 1'b1;
        exc  <= resExcept;
        misp <= resMispredict;
      end
    end

    // Payload needs no reset: it is only read behind the valid bits.
    always_ff @(posedge clk) begin
      if (hitIssue && !strb.doFlush) begin
        kind <= issueKind;
        dest <= issueDest;
      end
      if (hitRes && !strb.doFlush && !hitRetire) begin
        value <= resValue;
      end
    end

    assign entValid[e] = vld;
    assign entReady[e] = rdy;
    assign entExc[e]   = exc;
    assign entMisp[e]  = misp;
    assign entKind[e]  = kind;
    assign entDest[e]  = dest;
    assign entValue[e] = value;
  end

  assign headValid = entValid[headIdx];
  assign headReady = entReady[headIdx];
  assign headExc   = entExc[headIdx];
  assign headMisp  = entMisp[headIdx];
  assign headKind  = entKind[headIdx];

  assign regIdx  = entDest[headIdx][REG_W-1:0];
  assign regData = entValue[headIdx];
  assign memAddr = entDest[headIdx];
  assign memData = entValue[headIdx];

  assign lookupValid = entValid[lookupTag] && entReady[lookupTag];
  assign lookupValue = entValue[lookupTag];

  always_comb begin
    loadBlock = 1'b0;
    for (int e = 0; e < DEPTH; e++) begin
      if (entValid[e] && (entKind[e] == KIND_STORE) && (entDest[e] == loadAddr)) begin
        loadBlock = 1'b1;
      end
    end
  end

  // R3: an allocation never lands on an occupied slot
  assert_issue_free_slot_R3: assert property (@(posedge clk) disable iff (!rstN)
    strb.doIssue |-> !entValid[tailIdx]);

  // R5: retirement only of an occupied, finished oldest slot
  assert_retire_ready_R5: assert property (@(posedge clk) disable iff (!rstN)
    strb.doRetire |-> (entValid[headIdx] && entReady[headIdx]));

  // R9: nothing survives a flush, so stale results find no target
  assert_flush_clears_R9: assert property (@(posedge clk) disable iff (!rstN)
    strb.doFlush |=> (entValid == '0));

endmodule

// File: rtl/spec_rob.sv
module spec_rob
  import rob_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 32,
  parameter int DEST_W = 16,
  parameter int REG_W  = 5,
  localparam int TAG_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              issueValid,
  input  logic [1:0]        issueKind,
  input  logic [DEST_W-1:0] issueDest,
  input  logic              rsFree,
  output logic              issueGrant,
  output logic [TAG_W-1:0]  issueTag,
  input  logic              resValid,
  input  logic [TAG_W-1:0]  resTag,
  input  logic [DATA_W-1:0] resValue,
  input  logic              resExcept,
  input  logic              resMispredict,
  input  logic [TAG_W-1:0]  lookupTag,
  output logic              lookupValid,
  output logic [DATA_W-1:0] lookupValue,
  input  logic [DEST_W-1:0] loadAddr,
  output logic              loadBlock,
  output logic              retireValid,
  output logic [TAG_W-1:0]  retireTag,
  output logic              regWe,
  output logic [REG_W-1:0]  regIdx,
  output logic [DATA_W-1:0] regData,
  output logic              memWe,
  output logic [DEST_W-1:0] memAddr,
  output logic [DATA_W-1:0] memData,
  output logic              flushOut,
  output logic              excTaken
);

  robStrobe_t       strb;
  logic [TAG_W-1:0] headIdx;
  logic [TAG_W-1:0] tailIdx;
  logic             headValid;
  logic             headReady;
  logic             headExc;
  logic             headMisp;
  robKind_e         headKind;

  rob_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .issueValid (issueValid),
    .rsFree     (rsFree),
    .headValid  (headValid),
    .headReady  (headReady),
    .headExc    (headExc),
    .headMisp   (headMisp),
    .headKind   (headKind),
    .strb       (strb),
    .headIdx    (headIdx),
    .tailIdx    (tailIdx),
    .issueGrant (issueGrant),
    .retireValid(retireValid),
    .regWe      (regWe),
    .memWe      (memWe),
    .flushOut   (flushOut),
    .excTaken   (excTaken)
  );

  rob_data #(
    .DEPTH (DEPTH),
    .DATA_W(DATA_W),
    .DEST_W(DEST_W),
    .REG_W (REG_W)
  ) u_data (
    .clk          (clk),
    .rstN         (rstN),
    .strb         (strb),
    .headIdx      (headIdx),
    .tailIdx      (tailIdx),
    .issueKind    (robKind_e'(issueKind)),
    .issueDest    (issueDest),
    .resValid     (resValid),
    .resTag       (resTag),
    .resValue     (resValue),
    .resExcept    (resExcept),
    .resMispredict(resMispredict),
    .lookupTag    (lookupTag),
    .lookupValid  (lookupValid),
    .lookupValue  (lookupValue),
    .loadAddr     (loadAddr),
    .loadBlock    (loadBlock),
    .headValid    (headValid),
    .headReady    (headReady),
    .headExc      (headExc),
    .headMisp     (headMisp),
    .headKind     (headKind),
    .regIdx       (regIdx),
    .regData      (regData),
    .memAddr      (memAddr),
    .memData      (memData)
  );

  assign issueTag  = tailIdx;
  assign retireTag = headIdx;

endmodule

// File: tb/spec_rob_bench.sv
module spec_rob_bench;
  timeunit 1ns;
  timeprecision 100ps;

  localparam int DEPTH  = 8;
  localparam int DATA_W = 32;
  localparam int DEST_W = 16;
  localparam int REG_W  = 5;
  localparam int TAG_W  = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2.5 clk = ~clk;

  logic              issueValid = 0;
  logic [1:0]        issueKind = 0;
  logic [DEST_W-1:0] issueDest = 0;
  logic              rsFree = 0;
  logic              issueGrant;
  logic [TAG_W-1:0]  issueTag;
  logic              resValid = 0;
  logic [TAG_W-1:0]  resTag = 0;
  logic [DATA_W-1:0] resValue = 0;
  logic              resExcept = 0;
  logic              resMispredict = 0;
  logic [TAG_W-1:0]  lookupTag = 0;
  logic              lookupValid;
  logic [DATA_W-1:0] lookupValue;
  logic [DEST_W-1:0] loadAddr = 0;
  logic              loadBlock;
  logic              retireValid;
  logic [TAG_W-1:0]  retireTag;
  logic              regWe;
  logic [REG_W-1:0]  regIdx;
  logic [DATA_W-1:0] regData;
  logic              memWe;
  logic [DEST_W-1:0] memAddr;
  logic [DATA_W-1:0] memData;
  logic              flushOut;
  logic              excTaken;

  spec_rob #(.DEPTH(DEPTH), .DATA_W(DATA_W), .DEST_W(DEST_W), .REG_W(REG_W)) u_spec_rob (
    .clk(clk), .rstN(rstN),
    .issueValid(issueValid), .issueKind(issueKind), .issueDest(issueDest), .rsFree(rsFree),
    .issueGrant(issueGrant), .issueTag(issueTag),
    .resValid(resValid), .resTag(resTag), .resValue(resValue),
    .resExcept(resExcept), .resMispredict(resMispredict),
    .lookupTag(lookupTag), .lookupValid(lookupValid), .lookupValue(lookupValue),
    .loadAddr(loadAddr), .loadBlock(loadBlock),
    .retireValid(retireValid), .retireTag(retireTag),
    .regWe(regWe), .regIdx(regIdx), .regData(regData),
    .memWe(memWe), .memAddr(memAddr), .memData(memData),
    .flushOut(flushOut), .excTaken(excTaken)
  );

  int nChecks = 0;
  int nFail = 0;
  bit finished = 0;

  // Reference model of the buffer contents
  bit                mValid [DEPTH];
  bit                mReady [DEPTH];
  bit                mExc   [DEPTH];
  bit                mMisp  [DEPTH];
  logic [1:0]        mKind  [DEPTH];
  logic [DEST_W-1:0] mDest  [DEPTH];
  logic [DATA_W-1:0] mVal   [DEPTH];
  int mHead = 0;
  int mTail = 0;
  logic [31:0] seed = 32'h1234_5679;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] nextRnd();
    logic [31:0] x;
    x = seed;
    x = x ^ (x << 13);
    x = x ^ (x >> 17);
    x = x ^ (x << 5);
    seed = x;
    return x;
  endfunction

  // One clock: compare every output with the model, advance the model, pass the edge.
  task automatic cyc();
    int h;
    int occ;
    int lt;
    bit expRet, expExc, expFlush, expGrant, expL, expBlock;
    #1;
    h = mHead % DEPTH;
    occ = mTail - mHead;
    expRet = (occ > 0) && mReady[h];
    expExc = expRet && mExc[h];
    expFlush = expExc || (expRet && mKind[h] == 2'b10 && mMisp[h]);
    expGrant = issueValid && rsFree && (occ < DEPTH) && !expFlush;

    chk(retireValid == expRet, "R5", "retire strobe", retireValid, expRet);
    if (expRet) begin
      chk(retireTag == h[TAG_W-1:0], "R5", "retire tag", retireTag, h);
      chk(excTaken == expExc, "R7", "fault taken", excTaken, expExc);
      chk(flushOut == expFlush, "R6", "flush", flushOut, expFlush);
      chk(regWe == (!expExc && mKind[h] == 2'b00), "R2", "register write strobe", regWe, !expExc && mKind[h] == 2'b00);
      chk(memWe == (!expExc && mKind[h] == 2'b01), "R2", "memory write strobe", memWe, !expExc && mKind[h] == 2'b01);
      if (!expExc && mKind[h] == 2'b00) begin
        chk(regIdx == mDest[h][REG_W-1:0], "R2", "register index", regIdx, mDest[h][REG_W-1:0]);
        chk(regData == mVal[h], "R2", "register data", regData, mVal[h]);
      end
      if (!expExc && mKind[h] == 2'b01) begin
        chk(memAddr == mDest[h], "R2", "memory address", memAddr, mDest[h]);
        chk(memData == mVal[h], "R2", "memory data", memData, mVal[h]);
      end
    end else begin
      chk(!regWe && !memWe && !flushOut && !excTaken, "R5", "idle strobes",
          {regWe, memWe, flushOut, excTaken}, 0);
    end

    if (expFlush) chk(issueGrant == expGrant, "R10", "grant in flush cycle", issueGrant, expGrant);
    else if (occ >= DEPTH) chk(issueGrant == expGrant, "R3", "grant when full", issueGrant, expGrant);
    else chk(issueGrant == expGrant, "R1", "grant", issueGrant, expGrant);
    if (expGrant) chk(issueTag == TAG_W'(mTail % DEPTH), "R1", "issue tag", issueTag, mTail % DEPTH);

    lt = int'(lookupTag);
    expL = mValid[lt] && mReady[lt];
    chk(lookupValid == expL, "R4", "lookup valid", lookupValid, expL);
    if (expL) chk(lookupValue == mVal[lt], "R4", "lookup value", lookupValue, mVal[lt]);

    expBlock = 0;
    for (int e = 0; e < DEPTH; e++)
      if (mValid[e] && mKind[e] == 2'b01 && mDest[e] == loadAddr) expBlock = 1;
    chk(loadBlock == expBlock, "R8", "load conflict", loadBlock, expBlock);

    // model update
    if (resValid && mValid[resTag] && !expFlush && !(expRet && int'(resTag) == h)) begin
      mReady[resTag] = 1;
      mVal[resTag] = resValue;
      mExc[resTag] = resExcept;
      mMisp[resTag] = resMispredict;
    end
    if (expRet) begin
      mValid[h] = 0;
      mReady[h] = 0;
      mHead++;
    end
    if (expFlush) begin
      for (int e = 0; e < DEPTH; e++) begin
        mValid[e] = 0;
        mReady[e] = 0;
      end
      mTail = mHead;
    end else if (expGrant) begin
      h = mTail % DEPTH;
      mValid[h] = 1;
      mReady[h] = 0;
      mExc[h] = 0;
      mMisp[h] = 0;
      mKind[h] = issueKind;
      mDest[h] = issueDest;
      mTail++;
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic issueOne(input logic [1:0] kind, input logic [DEST_W-1:0] dest);
    issueValid = 1; rsFree = 1; issueKind = kind; issueDest = dest;
    cyc();
    issueValid = 0;
  endtask

  task automatic resultOne(input int tag, input logic [DATA_W-1:0] val, input bit exc, input bit misp);
    resValid = 1; resTag = TAG_W'(tag); resValue = val; resExcept = exc; resMispredict = misp;
    cyc();
    resValid = 0; resExcept = 0; resMispredict = 0;
  endtask

  task automatic drain();
    for (int g = 0; g < 40 && mTail > mHead; g++) cyc();
  endtask

  initial begin
    #500000;
    if (!finished) begin
      finished = 1;
      nChecks++;
      nFail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

  initial begin
    int t0, tb, tc, td, ta, tr;
    repeat (3) @(negedge clk);
    rstN = 1;
    #1;
    // reset state: R1, R5, R8
    chk(issueTag == 0, "R1", "tag after reset", issueTag, 0);
    chk(!retireValid, "R5", "no retire after reset", retireValid, 0);
    chk(!lookupValid, "R4", "lookup after reset", lookupValid, 0);
    chk(!loadBlock, "R8", "no conflict after reset", loadBlock, 0);
    @(negedge clk);

    // R1: no reservation station, no grant
    issueValid = 1; rsFree = 0; issueKind = 2'b00; issueDest = 16'h3;
    cyc();
    issueValid = 0;

    // Fill with a kind mix, then one more request: R3
    for (int i = 0; i < DEPTH; i++) begin
      if (i == 3 || i == 7) issueOne(2'b10, 16'h0);
      else if (i == 1 || i == 5) issueOne(2'b01, 16'h100 + 16'(i));
      else issueOne(2'b00, 16'(i + 2));
    end
    issueOne(2'b00, 16'h9);

    // R8: a stored address blocks, a neighbour does not
    loadAddr = 16'h101; cyc();
    loadAddr = 16'h102; cyc();

    // Complete newest first; the oldest is last so nothing may retire early (R5)
    for (int i = DEPTH - 1; i >= 1; i--) begin
      resultOne(i, 32'hA000 + 32'(i * 17), 0, 0);
      lookupTag = TAG_W'(i);
      cyc();
    end
    lookupTag = 0;
    cyc();
    loadAddr = 16'h105;
    resultOne(0, 32'hBEEF, 0, 0);
    drain();
    cyc();

    // R6 and R10: mispredicted branch with finished younger work
    ta = mTail % DEPTH; issueOne(2'b00, 16'h11);
    tb = mTail % DEPTH; issueOne(2'b10, 16'h0);
    tc = mTail % DEPTH; issueOne(2'b00, 16'h12);
    td = mTail % DEPTH; issueOne(2'b01, 16'h200);
    resultOne(tc, 32'h1111, 0, 0);
    resultOne(td, 32'h2222, 0, 0);
    resultOne(tb, 32'h0, 0, 1);
    resultOne(ta, 32'h3333, 0, 0);
    issueValid = 1; rsFree = 1; issueKind = 2'b00; issueDest = 16'h15;
    cyc();
    cyc();
    issueValid = 0;
    chk(mTail == mHead, "R6", "model empty after flush", mTail - mHead, 0);
    tr = mTail % DEPTH;
    chk(tr == (tb + 1) % DEPTH, "R6", "restart slot", tr, (tb + 1) % DEPTH);

    // R9: stale result to a flushed slot, then reissue it
    resultOne(tr, 32'hDEAD, 0, 0);
    issueOne(2'b00, 16'h7);
    lookupTag = TAG_W'(tr);
    #1;
    chk(!lookupValid, "R9", "reissued slot not ready", lookupValid, 0);
    cyc();
    resultOne(tr, 32'h7777, 0, 0);
    drain();

    // R7: fault on an older register op behind a finished store
    t0 = mTail % DEPTH; issueOne(2'b00, 16'h1);
    ta = mTail % DEPTH; issueOne(2'b00, 16'h1c);
    tb = mTail % DEPTH; issueOne(2'b01, 16'h300);
    resultOne(tb, 32'h4444, 0, 0);
    resultOne(ta, 32'h5555, 1, 0);
    cyc();
    resultOne(t0, 32'h6666, 0, 0);
    drain();
    chk(mTail == mHead, "R7", "model empty after fault", mTail - mHead, 0);

    // Pseudo-random sweep across occupancies, wrap, faults and stale writes
    for (int c = 0; c < 4000; c++) begin
      logic [31:0] r;
      int off, pick;
      r = nextRnd();
      issueValid = r[0] | r[1];
      rsFree = r[2] | r[3] | r[4];
      issueKind = (r[7:6] == 2'b11) ? 2'b00 : r[7:6];
      issueDest = {12'h0, r[11:8]};
      lookupTag = r[25:23];
      loadAddr = {12'h0, r[29:26]};
      resValid = 0;
      if (r[12] | r[13]) begin
        pick = -1;
        off = int'(r[16:14]);
        for (int j = 0; j < DEPTH; j++)
          if (pick < 0 && mValid[(off + j) % DEPTH] && !mReady[(off + j) % DEPTH]) pick = (off + j) % DEPTH;
        if (r[30] & r[31] & r[12]) pick = off;
        if (pick >= 0) begin
          resValid = 1;
          resTag = TAG_W'(pick);
          resValue = nextRnd();
          resExcept = (r[20:17] == 4'h0);
          resMispredict = r[21] & r[22];
        end
      end
      cyc();
    end
    issueValid = 0; resValid = 0;
    for (int k = 0; k < DEPTH && mTail > mHead; k++) begin
      for (int j = 0; j < DEPTH; j++)
        if (mValid[j] && !mReady[j]) resultOne(j, 32'hC0DE0000 + 32'(j), 0, 0);
      drain();
    end
    chk(mTail == mHead, "R5", "all drained", mTail - mHead, 0);

    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

endmodule